// File: doc/BRIEF.md
# Error Status and Interrupt Register Block

This block collects error conditions reported by the stall logic of an external-memory interface and presents them to software as a small set of bus registers. There are three sticky error flags. One records a timeout. One records a read that was held back behind queued writes. One records a write that was held back because the write queue had no room. Each flag is armed by its own enable input. Software reads the flags from a status word and acknowledges them by writing ones to the same word.

A summary raw-interrupt bit reports whether any flag is set. A separate interrupt-enable bit gates that summary onto the interrupt request line. Any acknowledge write that carries a one in a flag position clears the addressed flags and also drops the interrupt-enable bit. Software must re-arm the enable explicitly after servicing the interrupt. Writes take effect one cycle after they are presented, so a read issued in the very next cycle still returns the earlier contents.

Top module: `err_irq_regs`

## Requirements
- R1: After reset, the status word, the enable word and the raw word all read as zero, and `irq` is low.
- R2: Register offsets (word address on `addr`) are: 0 = status, 1 = interrupt enable, 2 = raw summary. Every other offset reads as zero. Status bits 31:3, enable bits 31:1 and raw bits 31:1 always read zero, and writing ones to them changes nothing.
- R3: Status bit 2 (write-queue-full error) sets when `err_ev[2]` and `err_en[2]` are both high at a clock edge. It stays clear when `err_en[2]` is low.
- R4: Status bit 1 (read-stalled error) sets when `err_ev[1]` and `err_en[1]` are both high at a clock edge. It stays clear when `err_en[1]` is low.
- R5: Status bit 0 (timeout error) sets when `err_ev[0]` and `err_en[0]` are both high at a clock edge. It stays clear when `err_en[0]` is low.
- R6: Writing 0 to a status bit leaves it unchanged. Writing 1 to a status bit clears that bit only.
- R7: A status write with a 1 in any of bits 2:0 also clears the interrupt-enable bit (enable word bit 0).
- R8: Raw word bit 0 reads as 1 exactly when at least one status bit is set.
- R9: `irq` is high exactly when raw bit 0 and the interrupt-enable bit are both 1.
- R10: A read presented on `rd_en` returns its data on `rdata`, with `rvalid` high, in the following cycle. A read presented in the cycle right after a write returns the contents as they were before that write. A read presented two cycles after the write returns the updated contents.
- R11: If a status bit's enabled error event arrives in the same cycle as a write-one-to-clear to that bit takes effect, the bit remains set.
- R12: A status bit stays set after its event input returns low, until software clears it.
- R13: Enable word bit 0 is readable and writable, and it can be set again after an automatic clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Word offset of the register accessed |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid one cycle after `rd_en` |
| rvalid | output | 1 | High in the cycle `rdata` holds a read result |
| err_en | input | NUM_ERR (3) | Per-flag capture enables (bit 2 write-full, bit 1 read-stall, bit 0 timeout) |
| err_ev | input | NUM_ERR (3) | Per-flag error events from the stall logic |
| irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
Two things can happen in the same cycle: an enabled error event on a flag, and the delayed write-one-to-clear for that same flag. The bench provokes this by presenting an acknowledge write and then pulsing the matching event in the next cycle, which is the cycle in which the staged clear is applied. It then reads the status back. The test passes if the flag is still set and the interrupt-enable bit has still been dropped by the acknowledge.

// File: rtl/err_irq_pkg.sv
`timescale 1ns/1ps
// Package: register selection type and offset decode shared by the
// error/interrupt register block. Assumes word addressing.
package err_irq_pkg;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_IEN    = 1;
    localparam int unsigned OFS_RAW    = 2;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IEN    = 2'd2,
        SEL_RAW    = 2'd3
    } reg_sel_e;

    // Map a word offset onto the register it selects.
    function automatic reg_sel_e decode_sel(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_STATUS: s = SEL_STATUS;
            OFS_IEN:    s = SEL_IEN;
            OFS_RAW:    s = SEL_RAW;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/err_wr_stage.sv
`timescale 1ns/1ps
// Module: err_wr_stage
// Registers an incoming bus write and turns it into a staged clear mask
// for the status flags plus a staged enable-bit write. The staged request
// takes effect one cycle later, which gives the one-cycle write-to-read
// visibility delay. Assumes ADDR_W <= 32 and NUM_ERR <= DATA_W.
module err_wr_stage
    import err_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_ERR-1:0] clr_mask,
    output logic               ien_wr,
    output logic               ien_val
);

    reg_sel_e wsel;

    // Decode which register the write targets.
    always_comb wsel = decode_sel(32'(addr));

    // Capture the write for application in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_mask <= '0;
            ien_wr   <= 1'b0;
            ien_val  <= 1'b0;
        end else begin
            clr_mask <= (wr_en && wsel == SEL_STATUS) ? wdata[NUM_ERR-1:0] : '0;
            ien_wr   <= wr_en && (wsel == SEL_IEN);
            ien_val  <= wdata[0];
        end
    end

endmodule

// File: rtl/err_status.sv
`timescale 1ns/1ps
// Module: err_status
// Holds one sticky flag per error source. A flag sets on an enabled event
// and clears on a staged write-one-to-clear. An event in the same cycle
// as a clear wins. Assumes events are sampled at the clock edge.
module err_status #(
    parameter int unsigned NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] ev,
    input  logic [NUM_ERR-1:0] en,
    input  logic [NUM_ERR-1:0] clr,
    output logic [NUM_ERR-1:0] flags
);

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
        // Per-source sticky flag with event priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (ev[i] && en[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end

        assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && en[i] && clr[i]) |=> flags[i]);

        assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);

        // Covers R3, R4 and R5: a flag only rises on an enabled event.
        assert_gated_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(ev[i] && en[i]));
    end

endmodule

// File: rtl/err_irq_ctrl.sv
`timescale 1ns/1ps
// Module: err_irq_ctrl
// Forms the summary raw-interrupt bit from the flags and keeps the
// interrupt-enable bit. Any staged clear drops the enable. The request
// output is the raw bit gated by the enable.
module err_irq_ctrl #(
    parameter int unsigned NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] flags,
    input  logic [NUM_ERR-1:0] clr,
    input  logic               ien_wr,
    input  logic               ien_val,
    output logic               raw,
    output logic               ien,
    output logic               irq
);

    // Summary of all flags.
    always_comb raw = |flags;

    // Request combines summary and enable.
    always_comb irq = raw && ien;

    // Enable bit: auto-clear on acknowledge, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= 1'b0;
        else if (|clr)
            ien <= 1'b0;
        else if (ien_wr)
            ien <= ien_val;
    end

    assert_ien_autoclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> !ien);

    assert_ien_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|clr) && !ien_wr) |=> $stable(ien));

endmodule

// File: rtl/err_irq_regs.sv
`timescale 1ns/1ps
// Module: err_irq_regs (top)
// Error status / interrupt register block. Writes pass through a one-cycle
// stage, flags and the enable live in sub-blocks, and reads are returned
// registered one cycle after the strobe. Assumes at most one access per
// cycle from the bus side.
module err_irq_regs
    import err_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid,
    input  logic [NUM_ERR-1:0] err_en,
    input  logic [NUM_ERR-1:0] err_ev,
    output logic               irq
);

    localparam int unsigned PAD_W = DATA_W - NUM_ERR;

    logic [NUM_ERR-1:0] clr_mask;
    logic               ien_wr;
    logic               ien_val;
    logic [NUM_ERR-1:0] flags;
    logic               raw;
    logic               ien;
    reg_sel_e           rsel;
    logic [DATA_W-1:0]  rd_mux;

    err_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ERR(NUM_ERR)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .clr_mask(clr_mask), .ien_wr(ien_wr), .ien_val(ien_val)
    );

    err_status #(.NUM_ERR(NUM_ERR)) u_st (
        .clk(clk), .rst_n(rst_n), .ev(err_ev), .en(err_en), .clr(clr_mask),
        .flags(flags)
    );

    err_irq_ctrl #(.NUM_ERR(NUM_ERR)) u_ic (
        .clk(clk), .rst_n(rst_n), .flags(flags), .clr(clr_mask),
        .ien_wr(ien_wr), .ien_val(ien_val), .raw(raw), .ien(ien), .irq(irq)
    );

    // Decode the read target.
    always_comb rsel = decode_sel(32'(addr));

    // Select read data, reserved bits forced to zero.
    always_comb begin
        case (rsel)
            SEL_STATUS: rd_mux = {{PAD_W{1'b0}}, flags};
            SEL_IEN:    rd_mux = {{(DATA_W-1){1'b0}}, ien};
            SEL_RAW:    rd_mux = {{(DATA_W-1){1'b0}}, raw};
            default:    rd_mux = '0;
        endcase
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= rd_mux;
        end
    end

    assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && (|flags)));

endmodule

// File: tb/sim_err_irq_regs.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them when rvalid appears. Inputs change on the falling edge.
module sim_err_irq_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid;
    logic [2:0]  err_en, err_ev;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    err_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err_en(err_en),
        .err_ev(err_ev), .irq(irq)
    );

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        err_ev[idx] = 1'b1;
        @(negedge clk);
        err_ev[idx] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    // Monitor: compare each returned read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected read actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        err_en = '0; err_ev = '0;
        idle(3);
        rst_n = 1'b1;
        check_irq(1'b0, "R1");
        bus_read(4'd0, 32'h0, "R1 status");
        bus_read(4'd1, 32'h0, "R1 ien");
        bus_read(4'd2, 32'h0, "R1 raw");

        err_en = 3'b111;
        bus_write(4'd1, 32'h1); idle(1);
        pulse(2);
        bus_read(4'd0, 32'h4, "R3 wfull set");
        bus_read(4'd2, 32'h1, "R8 raw set");
        check_irq(1'b1, "R9 irq on");

        bus_write(4'd0, 32'h0); idle(1);
        bus_read(4'd0, 32'h4, "R6 zero write");
        bus_read(4'd1, 32'h1, "R6 ien kept");

        pulse(1);
        bus_read(4'd0, 32'h6, "R4 rstall set");
        pulse(0);
        bus_read(4'd0, 32'h7, "R5 timeout set");

        bus_write(4'd0, 32'hFFFF_FFF8); idle(1);
        bus_read(4'd0, 32'h7, "R2 reserved write");
        bus_read(4'd1, 32'h1, "R2 ien untouched");

        bus_write(4'd0, 32'h2); idle(1);
        bus_read(4'd0, 32'h5, "R6 clear one bit");
        bus_read(4'd1, 32'h0, "R7 ien autoclear");
        bus_read(4'd2, 32'h1, "R8 raw still set");
        check_irq(1'b0, "R9 irq off");

        bus_write(4'd1, 32'hFFFF_FFFF); idle(1);
        bus_read(4'd1, 32'h1, "R13 ien rearm");
        check_irq(1'b1, "R13 irq back");

        bus_write(4'd0, 32'h4);
        bus_read(4'd0, 32'h5, "R10 old contents");
        bus_read(4'd0, 32'h1, "R10 new contents");

        bus_write(4'd1, 32'h1); idle(1);
        bus_write(4'd0, 32'h1);
        pulse(0);
        bus_read(4'd0, 32'h1, "R11 event wins");
        bus_read(4'd1, 32'h0, "R11 ien cleared");

        err_en = 3'b000;
        pulse(2); pulse(1);
        bus_read(4'd0, 32'h1, "R3 R4 gated off");
        bus_write(4'd0, 32'h1); idle(1);
        bus_read(4'd0, 32'h0, "R5 cleared");
        bus_read(4'd2, 32'h0, "R8 raw clear");
        pulse(0);
        bus_read(4'd0, 32'h0, "R5 gated off");

        err_en = 3'b010;
        err_ev[1] = 1'b1; idle(3); err_ev[1] = 1'b0;
        idle(4);
        bus_read(4'd0, 32'h2, "R12 sticky");
        idle(2);
        bus_read(4'd0, 32'h2, "R12 still sticky");
        bus_read(4'd5, 32'h0, "R2 unmapped");
        idle(3);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R10 missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule